// File: doc/BRIEF.md
# Serial link status exchange controller

This block moves link status from a PHY to a MAC across a serial gigabit link. It does this with 16-bit configuration words, and the same RTL serves both ends. A parameter chooses the role. The words and their valid strobes pass to and from a line encoder/decoder outside this block, so the block does no 8b/10b coding and no ordered-set framing.

On the PHY side the block watches three status inputs: link up, full duplex and a two-bit speed code. When any of them differs from the status it last advertised, it captures the new status and leaves data mode. It then sends the status word every cycle. The exchange ends at the first expiry of a shortened link timer by which the MAC has acknowledged. On the MAC side the block checks each received word. It adopts link, duplex and speed only once the same legal word has arrived several times in a row, and it answers each agreed word with an acknowledge word.

Top module: `lnkx_status_exchange`

## Requirements
- R1: In PHY role the transmitted word carries link at bit 15, full duplex at bit 12 and speed at bits 11:10, with speed codes 2'b10 = 1000 Mb/s, 2'b01 = 100 Mb/s and 2'b00 = 10 Mb/s. Bit 0 is 1 and bits 14, 13 and 9:1 are 0.
- R2: In MAC role the answer word is 16'h4001 (bit 14 acknowledge, bit 0 set, all other bits 0).
- R3: In PHY role, after reset the block is in data mode with cfg_word_valid and cfg_mode low and all status outputs 0. One clock after the status inputs differ from the advertised status, cfg_mode and cfg_word_valid go high, and a word is sent every cycle.
- R4: In PHY role only a received word equal to 16'h4001 with its valid strobe counts as acknowledge. Other words, and any word received in data mode, change nothing.
- R5: In PHY role the block returns to data mode at the first link timer expiry, counted every LINK_TIMER_CYCLES clocks from entry into configuration mode, at which an acknowledge has been seen. An acknowledge in the expiry cycle itself counts. Configuration mode therefore lasts a whole multiple of LINK_TIMER_CYCLES clocks.
- R6: In PHY role, a status change during an exchange restarts it. The new word is sent from the next cycle, any acknowledge already received is dropped, and the link timer starts again.
- R7: In MAC role the status outputs take the decoded value of a word one clock after the AGREE_COUNT-th consecutive identical legal word has been received. Cycles without the valid strobe neither count nor break the run.
- R8: In MAC role a word with bit 0 clear, any of bits 14, 13 or 9:1 set, or speed 2'b11 is illegal. It clears the run count and leaves the status outputs unchanged.
- R9: In MAC role cfg_word_valid and cfg_mode are high for one clock after each legal word received once agreement has been reached, and low otherwise.
- R10: In PHY role the status outputs show the status currently being advertised, captured when the exchange starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_link_in | input | 1 | PHY role: link up |
| st_full_dup_in | input | 1 | PHY role: full duplex |
| st_speed_in | input | 2 | PHY role: speed code |
| cfg_rx_valid | input | 1 | Received word strobe from the decoder |
| cfg_rx_word | input | 16 | Received configuration word |
| cfg_word_valid | output | 1 | Transmit word strobe to the encoder |
| cfg_word | output | 16 | Transmit configuration word |
| cfg_mode | output | 1 | High while configuration words replace data |
| st_link_out | output | 1 | Advertised (PHY) or agreed (MAC) link |
| st_full_dup_out | output | 1 | Advertised or agreed duplex |
| st_speed_out | output | 2 | Advertised or agreed speed code |

## Verification
The hardest situations to reach from the ports are the ones where several events fall in the same or nearby cycles. An acknowledge can land exactly in the link timer expiry cycle. A status change can arrive after an acknowledge was already accepted but before the timer expired. In that second case a wrong design would leave early on the stale acknowledge. The bench runs the PHY engine with a 16-cycle timer and indexes every configuration cycle from entry. It then places the acknowledge, a non-acknowledge word and the status change at chosen cycle indices. The length of configuration mode is predicted as a multiple of the timer period and compared with the observed length.

// File: rtl/lnkx_pkg.sv
package lnkx_pkg;

  typedef struct packed {
    logic       link;
    logic       full_dup;
    logic [1:0] speed;
  } lnk_stat_t;

  typedef enum logic {PH_DATA = 1'b0, PH_CFG = 1'b1} phy_state_e;

  localparam logic [15:0] ACK_WORD = 16'h4001;

  function automatic logic [15:0] encode_stat(lnk_stat_t s);
    return {s.link, 2'b00, s.full_dup, s.speed, 9'd0, 1'b1};
  endfunction

  function automatic logic word_legal(logic [15:0] w);
    return w[0] && !w[14] && !w[13] && (w[9:1] == 9'd0) && (w[11:10] != 2'b11);
  endfunction

  function automatic lnk_stat_t decode_stat(logic [15:0] w);
    lnk_stat_t s;
    s.link     = w[15];
    s.full_dup = w[12];
    s.speed    = w[11:10];
    return s;
  endfunction

endpackage

// File: rtl/lnkx_link_timer.sv
module lnkx_link_timer #(
  parameter int CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] TOP = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = run && (cnt_q == '0);
  assign cnt_en  = load || run;

  always_comb begin
    cnt_d = cnt_q;
    if (load || cnt_q == '0) cnt_d = TOP;
    else                     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= TOP;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: count never leaves the period range
  a_r5_timer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

endmodule

// File: rtl/lnkx_phy_engine.sv
module lnkx_phy_engine
  import lnkx_pkg::*;
#(
  parameter int LINK_TIMER_CYCLES = 200000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  lnk_stat_t   stat_in,
  input  logic        rx_valid,
  input  logic [15:0] rx_word,
  output logic        tx_valid,
  output logic [15:0] tx_word,
  output logic        cfg_active,
  output lnk_stat_t   adv_stat
);
  phy_state_e state_q, state_d;
  lnk_stat_t  snap_q, snap_d;
  logic       ack_q, ack_d;
  logic       changed, ack_now, tmr_expired, tmr_run;

  assign changed = (stat_in != snap_q);
  assign ack_now = rx_valid && (rx_word == ACK_WORD);
  assign tmr_run = (state_q == PH_CFG);

  lnkx_link_timer #(.CYCLES(LINK_TIMER_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (changed),
    .run     (tmr_run),
    .expired (tmr_expired)
  );

  always_comb begin
    state_d = state_q;
    snap_d  = snap_q;
    ack_d   = ack_q;
    if (changed) begin
      state_d = PH_CFG;
      snap_d  = stat_in;
      ack_d   = 1'b0;
    end else if (state_q == PH_CFG) begin
      if (tmr_expired && (ack_q || ack_now)) begin
        state_d = PH_DATA;
        ack_d   = 1'b0;
      end else if (ack_now) begin
        ack_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_DATA;
      snap_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      snap_q  <= snap_d;
      ack_q   <= ack_d;
    end
  end

  assign cfg_active = (state_q == PH_CFG);
  assign tx_valid   = cfg_active;
  assign tx_word    = encode_stat(snap_q);
  assign adv_stat   = snap_q;

  // R3: a status difference in data mode leads to configuration mode
  a_r3_change_enters_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_DATA && stat_in != snap_q) |=> (tx_valid && cfg_active));

  // R5: leaving configuration mode only on a timer expiry
  a_r5_exit_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_active) |-> $past(tmr_expired));

  // R4: leaving configuration mode needs an acknowledge
  a_r4_exit_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_active) |-> ($past(ack_q) || $past(rx_valid && rx_word == ACK_WORD)));

  // R6: a status change mid-exchange keeps the exchange running
  a_r6_restart_stays_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_active && stat_in != snap_q) |=> cfg_active);

endmodule

// File: rtl/lnkx_mac_engine.sv
module lnkx_mac_engine
  import lnkx_pkg::*;
#(
  parameter int AGREE_COUNT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [15:0] rx_word,
  output logic        ack_valid,
  output lnk_stat_t   stat_out
);
  localparam int CNTW = $clog2(AGREE_COUNT + 1);
  localparam logic [CNTW-1:0] AGREE_V = CNTW'(AGREE_COUNT);

  logic [15:0]     last_q, last_d;
  logic [CNTW-1:0] run_q, run_d;
  lnk_stat_t       stat_q, stat_d;
  logic            ack_q, ack_d;
  logic            legal, agree;

  assign legal = word_legal(rx_word);

  always_comb begin
    last_d = last_q;
    run_d  = run_q;
    if (rx_valid) begin
      if (!legal) begin
        run_d = '0;
      end else if (rx_word == last_q) begin
        if (run_q != AGREE_V) run_d = run_q + 1'b1;
      end else begin
        last_d = rx_word;
        run_d  = CNTW'(1);
      end
    end
    agree  = rx_valid && legal && (run_d == AGREE_V);
    stat_d = agree ? decode_stat(rx_word) : stat_q;
    ack_d  = agree;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      run_q  <= '0;
      stat_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      last_q <= last_d;
      run_q  <= run_d;
      stat_q <= stat_d;
      ack_q  <= ack_d;
    end
  end

  assign ack_valid = ack_q;
  assign stat_out  = stat_q;

  // R7: applied status moves only after a received word
  a_r7_moves_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_q) |-> $past(rx_valid));

  // R9: an answer follows a received word with bit 0 set and bit 14 clear
  a_r9_ack_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> ($past(rx_valid) && $past(rx_word[0]) && !$past(rx_word[14])));

  // R8: the reserved speed code is never adopted
  a_r8_no_reserved_speed: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q.speed != 2'b11);

endmodule

// File: rtl/lnkx_status_exchange.sv
module lnkx_status_exchange
  import lnkx_pkg::*;
#(
  parameter bit PHY_SIDE          = 1'b1,
  parameter int LINK_TIMER_CYCLES = 200000,
  parameter int AGREE_COUNT       = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        st_link_in,
  input  logic        st_full_dup_in,
  input  logic [1:0]  st_speed_in,
  input  logic        cfg_rx_valid,
  input  logic [15:0] cfg_rx_word,
  output logic        cfg_word_valid,
  output logic [15:0] cfg_word,
  output logic        cfg_mode,
  output logic        st_link_out,
  output logic        st_full_dup_out,
  output logic [1:0]  st_speed_out
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  lnk_stat_t   st_in, phy_stat, mac_stat, sel_stat;
  logic        phy_tx_valid, phy_cfg, mac_ack;
  logic [15:0] phy_tx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign st_in = {st_link_in, st_full_dup_in, st_speed_in};

  lnkx_phy_engine #(.LINK_TIMER_CYCLES(LINK_TIMER_CYCLES)) u_phy (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .stat_in    (st_in),
    .rx_valid   (cfg_rx_valid),
    .rx_word    (cfg_rx_word),
    .tx_valid   (phy_tx_valid),
    .tx_word    (phy_tx_word),
    .cfg_active (phy_cfg),
    .adv_stat   (phy_stat)
  );

  lnkx_mac_engine #(.AGREE_COUNT(AGREE_COUNT)) u_mac (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rx_valid  (cfg_rx_valid),
    .rx_word   (cfg_rx_word),
    .ack_valid (mac_ack),
    .stat_out  (mac_stat)
  );

  assign cfg_word_valid  = PHY_SIDE ? phy_tx_valid : mac_ack;
  assign cfg_word        = PHY_SIDE ? phy_tx_word  : ACK_WORD;
  assign cfg_mode        = PHY_SIDE ? phy_cfg      : mac_ack;
  assign sel_stat        = PHY_SIDE ? phy_stat     : mac_stat;
  assign st_link_out     = sel_stat.link;
  assign st_full_dup_out = sel_stat.full_dup;
  assign st_speed_out    = sel_stat.speed;

endmodule

// File: tb/lnkx_status_exchange_bench.sv
module lnkx_status_exchange_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LT         = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        p_link = 0, p_dup = 0;
  logic [1:0]  p_spd = 0;
  logic        p_rx_valid = 0;
  logic [15:0] p_rx_word = 0;
  logic        p_tx_valid, p_cfg, p_lo, p_do;
  logic [15:0] p_tx_word;
  logic [1:0]  p_so;

  logic        m_rx_valid = 0;
  logic [15:0] m_rx_word = 0;
  logic        m_tx_valid, m_cfg, m_lo, m_do;
  logic [15:0] m_tx_word;
  logic [1:0]  m_so;

  lnkx_status_exchange #(.PHY_SIDE(1'b1), .LINK_TIMER_CYCLES(LT), .AGREE_COUNT(3)) u_lnkx_status_exchange (
    .clk(clk), .rst_n(rst_n), .st_link_in(p_link), .st_full_dup_in(p_dup), .st_speed_in(p_spd),
    .cfg_rx_valid(p_rx_valid), .cfg_rx_word(p_rx_word), .cfg_word_valid(p_tx_valid),
    .cfg_word(p_tx_word), .cfg_mode(p_cfg), .st_link_out(p_lo), .st_full_dup_out(p_do),
    .st_speed_out(p_so));

  lnkx_status_exchange #(.PHY_SIDE(1'b0), .LINK_TIMER_CYCLES(LT), .AGREE_COUNT(3)) u_lnkx_status_exchange_mac (
    .clk(clk), .rst_n(rst_n), .st_link_in(1'b0), .st_full_dup_in(1'b0), .st_speed_in(2'b00),
    .cfg_rx_valid(m_rx_valid), .cfg_rx_word(m_rx_word), .cfg_word_valid(m_tx_valid),
    .cfg_word(m_tx_word), .cfg_mode(m_cfg), .st_link_out(m_lo), .st_full_dup_out(m_do),
    .st_speed_out(m_so));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [3:0] s);
    return {s[3], 2'b00, s[2], s[1:0], 9'd0, 1'b1};
  endfunction

  // {valid, word, link, dup, speed, ack}
  localparam int NV = 22;
  localparam logic [21:0] MVEC [NV] = '{
    {1'b1, 16'h9801, 1'b0, 1'b0, 2'b00, 1'b0},
    {1'b1, 16'h9801, 1'b0, 1'b0, 2'b00, 1'b0},
    {1'b1, 16'h9801, 1'b1, 1'b1, 2'b10, 1'b1},
    {1'b1, 16'h9801, 1'b1, 1'b1, 2'b10, 1'b1},
    {1'b1, 16'h8401, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 16'h8401, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 16'h9801, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 16'h8401, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 16'h8401, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 16'h8C01, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 16'h8C01, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 16'h8C01, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 16'h4001, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 16'h8401, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 16'h8401, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b0, 16'h0001, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 16'h8401, 1'b1, 1'b0, 2'b01, 1'b1},
    {1'b1, 16'h0001, 1'b1, 1'b0, 2'b01, 1'b0},
    {1'b1, 16'h8400, 1'b1, 1'b0, 2'b01, 1'b0},
    {1'b1, 16'h0001, 1'b1, 1'b0, 2'b01, 1'b0},
    {1'b1, 16'h0001, 1'b1, 1'b0, 2'b01, 1'b0},
    {1'b1, 16'h0001, 1'b0, 1'b0, 2'b00, 1'b1}
  };

  // drives s1, then indexes configuration cycles n = 1, 2, ...
  task automatic phy_session(input logic [3:0] s1, input int ack_a, input int ack_b,
                             input int chg_at, input logic [3:0] s2, input int junk_at,
                             output int n, output logic [3:0] fin);
    logic [3:0] cur;
    cur = s1;
    n = 0;
    @(negedge clk);
    {p_link, p_dup, p_spd} = s1;
    @(posedge clk);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!p_tx_valid) break;
      n++;
      check("R1 word", {16'd0, p_tx_word},
            {16'd0, exp_word((chg_at != 0 && n > chg_at) ? s2 : s1)});
      p_rx_valid = (n == ack_a) || (n == ack_b) || (n == junk_at);
      p_rx_word  = (n == junk_at) ? 16'hC001 : 16'h4001;
      if (n == chg_at) begin
        {p_link, p_dup, p_spd} = s2;
        cur = s2;
      end
    end
    p_rx_valid = 1'b0;
    check("R3 cfg_mode low after exchange", {31'd0, p_cfg}, 32'd0);
    check("R10 advertised status", {28'd0, p_lo, p_do, p_so}, {28'd0, cur});
    fin = cur;
  endtask

  initial begin
    int n;
    logic [3:0] fin;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 reset state, both roles
    check("R3 phy reset valid", {31'd0, p_tx_valid}, 32'd0);
    check("R3 phy reset cfg_mode", {31'd0, p_cfg}, 32'd0);
    check("R3 phy reset status", {28'd0, p_lo, p_do, p_so}, 32'd0);
    check("R9 mac reset valid", {31'd0, m_tx_valid}, 32'd0);
    check("R7 mac reset status", {28'd0, m_lo, m_do, m_so}, 32'd0);

    // R4: acknowledge in data mode changes nothing
    p_rx_valid = 1'b1; p_rx_word = 16'h4001;
    @(negedge clk);
    p_rx_valid = 1'b0;
    @(negedge clk);
    check("R4 ack in data mode ignored", {31'd0, p_tx_valid}, 32'd0);

    // MAC table walk: R7 R8 R9 R2
    for (int i = 0; i < NV; i++) begin
      m_rx_valid = MVEC[i][21];
      m_rx_word  = MVEC[i][20:5];
      @(negedge clk);
      check($sformatf("R7/R8 mac status vec %0d", i), {28'd0, m_lo, m_do, m_so}, {28'd0, MVEC[i][4:1]});
      check($sformatf("R9 mac ack vec %0d", i), {31'd0, m_tx_valid}, {31'd0, MVEC[i][0]});
      check($sformatf("R9 mac cfg_mode vec %0d", i), {31'd0, m_cfg}, {31'd0, MVEC[i][0]});
      if (MVEC[i][0]) check("R2 ack word", {16'd0, m_tx_word}, 32'h4001);
    end
    m_rx_valid = 1'b0;

    // R5: early acknowledge, one period
    phy_session(4'b1110, 3, 0, 0, 4'b0000, 0, n, fin);
    check("R5 early ack length", n, LT);
    // R5: acknowledge in the expiry cycle counts
    phy_session(4'b1001, LT, 0, 0, 4'b0000, 0, n, fin);
    check("R5 ack at expiry length", n, LT);
    // R4: no acknowledge for three periods, non-ack word ignored
    phy_session(4'b0000, 3*LT+2, 0, 0, 4'b0000, 5, n, fin);
    check("R4 late ack length", n, 4*LT);
    // R6: change after an accepted ack restarts and forgets it
    phy_session(4'b1101, 2, LT+7, 5, 4'b1010, 0, n, fin);
    check("R6 restart length", n, 2*LT+5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*50000);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule